// File: doc/BRIEF.md
# Fractional Video Line Timing Sequencer

The sequencer derives horizontal line ticks from the system clock when a line lasts a non-integer number of clocks. Each line adds a fixed-point increment with 12 fraction bits to a fraction register. The integer part of the sum gives the length of that line in clocks. The fraction left over carries into the next line, so the tick positions do not drift over time. A line counter turns the ticks into a vertical-blank start event and an end-of-frame event. An independent modulo counter raises an audio-update strobe on every 32nd line.

A one-bit standard select chooses the 60 Hz constant set or the 50 Hz constant set. The sequencer only takes the select in while reset is held and at the end of each frame, so a frame never mixes the two sets. The line tick can drive the line-clock input of a timer block. The other three outputs are event pulses for video, interrupt and audio logic.

Top module: `lts_line_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, every output is low after that edge. After release, the line count, the audio count and the fraction all start from zero, so the first `line_tick` is high in the clock before edge number floor(INC/2^12), counting the first edge with `rst` low as edge 1.
- R2: Within one standard, tick number k ends at edge floor(k*INC/2^12), counted from release. The fraction carries over, so a line lasts either floor(INC/2^12) or one more clock.
- R3: With default parameters, INC is 8791293 (about 2146.31 clocks) for `std_sel`=0 (60 Hz) and 8864320 (about 2164.14 clocks) for `std_sel`=1 (50 Hz).
- R4: `vblank_start` is high together with the tick that ends line index VBLANK_LINE-1, so the line count reaches 240 (60 Hz) or 256 (50 Hz). This happens once per frame.
- R5: `frame_wrap` is high together with the tick that ends line index FRAME_LINES-1 (263 lines at 60 Hz, 313 at 50 Hz). The next line is index 0.
- R6: `audio_strobe` is high with every AUDIO_LINES-th tick (default 32), counted from reset. Frame wrap does not restart this count.
- R7: `std_sel`=0 selects the 60 Hz set and 1 selects the 50 Hz set. It is captured at each edge with `rst` high and at the edge that ends a frame. The captured set governs the increment and the line counts from the next line on.
- R8: A change of `std_sel` at any edge that does not end a frame leaves the tick timing, the line counts and all event outputs unchanged.
- R9: `vblank_start`, `frame_wrap` and `audio_strobe` are one-cycle pulses that are high only in a cycle where `line_tick` is high. `line_tick` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| std_sel | input | 1 | Standard select: 0 = 60 Hz set, 1 = 50 Hz set |
| line_tick | output | 1 | High for one clock at the end of each line |
| vblank_start | output | 1 | High with the tick that starts vertical blank |
| frame_wrap | output | 1 | High with the tick that ends the frame |
| audio_strobe | output | 1 | High with every AUDIO_LINES-th tick |

## Verification
All four outputs are decoded without a register from the state, so each one is due in the same cycle in which the line counter is one clock short of its end. That is the interval after edge floor(k*INC/2^12)-1. The bench samples every output at the falling edge of every clock and compares it with a model that tracks the edge count and the cumulative fixed-point boundary. A select value driven at a falling edge counts only at the next rising edge, and only when that edge ends a frame. The model therefore switches its constant set in the same step that it predicts the wrap, and it uses the new set for the next line's boundary. Two further instances keep the default constants and are checked against floor(k*INC/2^12) over their first twenty lines.

// File: rtl/lts_pkg.sv
package lts_pkg;

   typedef enum logic {
      STD_60HZ = 1'b0,
      STD_50HZ = 1'b1
   } video_std_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned width_for(input int unsigned count);
      return (count < 2) ? 1 : $clog2(count);
   endfunction

endpackage

// File: rtl/lts_frac_divider.sv
module lts_frac_divider #(
   parameter int unsigned ACC_W     = 32,
   parameter int unsigned FRAC_BITS = 12,
   parameter int unsigned INC_60    = 8791293,
   parameter int unsigned INC_50    = 8864320
) (
   input  logic                clk,
   input  logic                rst,
   input  lts_pkg::video_std_e std_act,
   output logic                line_tick
);
   localparam int unsigned INT_W = ACC_W - FRAC_BITS;
   localparam int unsigned SUM_W = ACC_W + 1;
   localparam logic [INT_W:0] ONE_P = 1;

   logic [ACC_W-1:0] inc;
   logic [INT_W-1:0] cnt_q;
   logic [INT_W:0]   period;

   assign inc = (std_act == lts_pkg::STD_50HZ) ? ACC_W'(INC_50) : ACC_W'(INC_60);

   generate
      if (FRAC_BITS > 0) begin : g_frac
         logic [FRAC_BITS-1:0] frac_q;
         logic [SUM_W-1:0]     sum;

         assign sum    = {1'b0, inc} + SUM_W'(frac_q);
         assign period = sum[SUM_W-1:FRAC_BITS];

         always_ff @(posedge clk) begin
            if (rst)            frac_q <= '0;
            else if (line_tick) frac_q <= sum[FRAC_BITS-1:0];
         end
      end else begin : g_int
         assign period = {1'b0, inc};
      end
   endgenerate

   assign line_tick = ({1'b0, cnt_q} == (period - ONE_P));

   always_ff @(posedge clk) begin
      if (rst)            cnt_q <= '0;
      else if (line_tick) cnt_q <= '0;
      else                cnt_q <= cnt_q + INT_W'(1);
   end

endmodule

// File: rtl/lts_line_counter.sv
module lts_line_counter #(
   parameter int unsigned LINE_W         = 9,
   parameter int unsigned VBLANK_LINE_60 = 240,
   parameter int unsigned FRAME_LINES_60 = 263,
   parameter int unsigned VBLANK_LINE_50 = 256,
   parameter int unsigned FRAME_LINES_50 = 313
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                line_tick,
   input  logic                std_sel,
   output lts_pkg::video_std_e std_act,
   output logic                vblank_start,
   output logic                frame_wrap
);
   logic [LINE_W-1:0] line_q;
   logic [LINE_W-1:0] last_line;
   logic [LINE_W-1:0] pre_blank;

   always_comb begin
      if (std_act == lts_pkg::STD_50HZ) begin
         last_line = LINE_W'(FRAME_LINES_50 - 1);
         pre_blank = LINE_W'(VBLANK_LINE_50 - 1);
      end else begin
         last_line = LINE_W'(FRAME_LINES_60 - 1);
         pre_blank = LINE_W'(VBLANK_LINE_60 - 1);
      end
   end

   assign frame_wrap   = line_tick && (line_q == last_line);
   assign vblank_start = line_tick && (line_q == pre_blank);

   always_ff @(posedge clk) begin
      if (rst) begin
         line_q  <= '0;
         std_act <= lts_pkg::video_std_e'(std_sel);
      end else if (line_tick) begin
         if (frame_wrap) begin
            line_q  <= '0;
            std_act <= lts_pkg::video_std_e'(std_sel);
         end else begin
            line_q  <= line_q + LINE_W'(1);
         end
      end
   end

endmodule

// File: rtl/lts_pulse_modulo.sv
module lts_pulse_modulo #(
   parameter int unsigned PERIOD = 32
) (
   input  logic clk,
   input  logic rst,
   input  logic step,
   output logic pulse
);
   generate
      if (PERIOD <= 1) begin : g_every
         assign pulse = step;
      end else begin : g_count
         localparam int unsigned W = lts_pkg::width_for(PERIOD);
         logic [W-1:0] cnt_q;
         logic         at_end;

         assign at_end = (cnt_q == W'(PERIOD - 1));
         assign pulse  = step && at_end;

         always_ff @(posedge clk) begin
            if (rst)       cnt_q <= '0;
            else if (step) cnt_q <= at_end ? '0 : cnt_q + W'(1);
         end
      end
   endgenerate

endmodule

// File: rtl/lts_line_sequencer.sv
module lts_line_sequencer #(
   parameter int unsigned ACC_W          = 32,
   parameter int unsigned FRAC_BITS      = 12,
   parameter int unsigned INC_60         = 8791293,
   parameter int unsigned INC_50         = 8864320,
   parameter int unsigned VBLANK_LINE_60 = 240,
   parameter int unsigned FRAME_LINES_60 = 263,
   parameter int unsigned VBLANK_LINE_50 = 256,
   parameter int unsigned FRAME_LINES_50 = 313,
   parameter int unsigned AUDIO_LINES    = 32
) (
   input  logic clk,
   input  logic rst,
   input  logic std_sel,
   output logic line_tick,
   output logic vblank_start,
   output logic frame_wrap,
   output logic audio_strobe
);
   localparam int unsigned MAX_LINES = lts_pkg::max_u(FRAME_LINES_60, FRAME_LINES_50);
   localparam int unsigned LINE_W    = lts_pkg::width_for(MAX_LINES);
   localparam int unsigned MIN_INC   = 2 << FRAC_BITS;

   generate
      if (FRAC_BITS >= ACC_W) begin : g_bad_frac
         $error("FRAC_BITS must be below ACC_W");
      end
      if (INC_60 < MIN_INC || INC_50 < MIN_INC) begin : g_bad_inc
         $error("each increment must give lines of at least two clocks");
      end
      if (VBLANK_LINE_60 < 1 || VBLANK_LINE_60 >= FRAME_LINES_60) begin : g_bad_v60
         $error("60 Hz blank line must lie inside the frame");
      end
      if (VBLANK_LINE_50 < 1 || VBLANK_LINE_50 >= FRAME_LINES_50) begin : g_bad_v50
         $error("50 Hz blank line must lie inside the frame");
      end
      if (AUDIO_LINES < 1) begin : g_bad_aud
         $error("AUDIO_LINES must be at least one");
      end
   endgenerate

   lts_pkg::video_std_e std_act;

   lts_frac_divider #(
      .ACC_W     (ACC_W),
      .FRAC_BITS (FRAC_BITS),
      .INC_60    (INC_60),
      .INC_50    (INC_50)
   ) u_div (
      .clk       (clk),
      .rst       (rst),
      .std_act   (std_act),
      .line_tick (line_tick)
   );

   lts_line_counter #(
      .LINE_W         (LINE_W),
      .VBLANK_LINE_60 (VBLANK_LINE_60),
      .FRAME_LINES_60 (FRAME_LINES_60),
      .VBLANK_LINE_50 (VBLANK_LINE_50),
      .FRAME_LINES_50 (FRAME_LINES_50)
   ) u_lines (
      .clk          (clk),
      .rst          (rst),
      .line_tick    (line_tick),
      .std_sel      (std_sel),
      .std_act      (std_act),
      .vblank_start (vblank_start),
      .frame_wrap   (frame_wrap)
   );

   lts_pulse_modulo #(
      .PERIOD (AUDIO_LINES)
   ) u_audio (
      .clk   (clk),
      .rst   (rst),
      .step  (line_tick),
      .pulse (audio_strobe)
   );

endmodule

// File: rtl/lts_line_sequencer_chk.sv
module lts_line_sequencer_chk #(
   parameter int unsigned FRAC_BITS      = 12,
   parameter int unsigned INC_60         = 8791293,
   parameter int unsigned INC_50         = 8864320,
   parameter int unsigned VBLANK_LINE_60 = 240,
   parameter int unsigned FRAME_LINES_60 = 263,
   parameter int unsigned VBLANK_LINE_50 = 256,
   parameter int unsigned FRAME_LINES_50 = 313,
   parameter int unsigned AUDIO_LINES    = 32
) (
   input logic                clk,
   input logic                rst,
   input logic                std_sel,
   input lts_pkg::video_std_e std_act,
   input logic                line_tick,
   input logic                vblank_start,
   input logic                frame_wrap,
   input logic                audio_strobe
);
   localparam int unsigned P60 = INC_60 >> FRAC_BITS;
   localparam int unsigned P50 = INC_50 >> FRAC_BITS;

   logic [31:0] gap_q, frame_q, aud_q;
   logic [31:0] cur_p, cur_vbl, cur_tot;
   logic        is50;

   assign is50    = (std_act == lts_pkg::STD_50HZ);
   assign cur_p   = is50 ? 32'(P50) : 32'(P60);
   assign cur_vbl = is50 ? 32'(VBLANK_LINE_50) : 32'(VBLANK_LINE_60);
   assign cur_tot = is50 ? 32'(FRAME_LINES_50) : 32'(FRAME_LINES_60);

   always_ff @(posedge clk) begin
      if (rst) begin
         gap_q   <= '0;
         frame_q <= '0;
         aud_q   <= '0;
      end else begin
         gap_q <= line_tick ? '0 : gap_q + 32'd1;
         if (line_tick) begin
            frame_q <= frame_wrap ? '0 : frame_q + 32'd1;
            aud_q   <= (aud_q == 32'(AUDIO_LINES - 1)) ? '0 : aud_q + 32'd1;
         end
      end
   end

   assert_line_len_R2: assert property (@(posedge clk) disable iff (rst)
      line_tick |-> ((gap_q + 32'd1 == cur_p) || (gap_q + 32'd1 == cur_p + 32'd1)));

   assert_vblank_line_R4: assert property (@(posedge clk) disable iff (rst)
      line_tick |-> (vblank_start == (frame_q == cur_vbl - 32'd1)));

   assert_frame_len_R5: assert property (@(posedge clk) disable iff (rst)
      line_tick |-> (frame_wrap == (frame_q == cur_tot - 32'd1)));

   assert_audio_period_R6: assert property (@(posedge clk) disable iff (rst)
      line_tick |-> (audio_strobe == (aud_q == 32'(AUDIO_LINES - 1))));

   assert_std_load_R7: assert property (@(posedge clk) disable iff (rst)
      frame_wrap |=> (std_act == lts_pkg::video_std_e'($past(std_sel))));

   assert_std_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !frame_wrap |=> $stable(std_act));

   assert_events_on_tick_R9: assert property (@(posedge clk) disable iff (rst)
      (vblank_start || frame_wrap || audio_strobe) |-> line_tick);

   assert_tick_single_R9: assert property (@(posedge clk) disable iff (rst)
      line_tick |=> !line_tick);

endmodule

bind lts_line_sequencer lts_line_sequencer_chk #(
   .FRAC_BITS      (FRAC_BITS),
   .INC_60         (INC_60),
   .INC_50         (INC_50),
   .VBLANK_LINE_60 (VBLANK_LINE_60),
   .FRAME_LINES_60 (FRAME_LINES_60),
   .VBLANK_LINE_50 (VBLANK_LINE_50),
   .FRAME_LINES_50 (FRAME_LINES_50),
   .AUDIO_LINES    (AUDIO_LINES)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .std_sel      (std_sel),
   .std_act      (std_act),
   .line_tick    (line_tick),
   .vblank_start (vblank_start),
   .frame_wrap   (frame_wrap),
   .audio_strobe (audio_strobe)
);

// File: tb/tb_lts_line_sequencer.sv
`timescale 1ns/1ps
module tb_lts_line_sequencer;
   localparam int unsigned T_INC60 = 21714;
   localparam int unsigned T_INC50 = 30720;
   localparam int unsigned T_VBL60 = 6;
   localparam int unsigned T_FR60  = 9;
   localparam int unsigned T_VBL50 = 8;
   localparam int unsigned T_FR50  = 11;
   localparam int unsigned T_AUD   = 4;
   localparam longint F_INC60 = 8791293;
   localparam longint F_INC50 = 8864320;
   localparam int F_LINES = 20;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic rst_full = 1'b1;
   logic std_sel = 1'b0;
   logic line_tick, vblank_start, frame_wrap, audio_strobe;
   logic t60, v60, w60, a60, t50, v50, w50, a50;

   always #4 clk = ~clk;

   lts_line_sequencer #(
      .INC_60(T_INC60), .INC_50(T_INC50),
      .VBLANK_LINE_60(T_VBL60), .FRAME_LINES_60(T_FR60),
      .VBLANK_LINE_50(T_VBL50), .FRAME_LINES_50(T_FR50),
      .AUDIO_LINES(T_AUD)
   ) dut (
      .clk(clk), .rst(rst), .std_sel(std_sel),
      .line_tick(line_tick), .vblank_start(vblank_start),
      .frame_wrap(frame_wrap), .audio_strobe(audio_strobe)
   );

   lts_line_sequencer dut60 (
      .clk(clk), .rst(rst_full), .std_sel(1'b0),
      .line_tick(t60), .vblank_start(v60), .frame_wrap(w60), .audio_strobe(a60)
   );

   lts_line_sequencer dut50 (
      .clk(clk), .rst(rst_full), .std_sel(1'b1),
      .line_tick(t50), .vblank_start(v50), .frame_wrap(w50), .audio_strobe(a50)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   longint m_n, m_bound;
   int     m_line, m_aud;
   bit     m_act, prev_tick, wait_first, full_run;
   longint f_n, f_k60, f_k50;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic longint inc_of(input bit s);
      return s ? longint'(T_INC50) : longint'(T_INC60);
   endfunction
   function automatic int vbl_of(input bit s);
      return s ? int'(T_VBL50) : int'(T_VBL60);
   endfunction
   function automatic int tot_of(input bit s);
      return s ? int'(T_FR50) : int'(T_FR60);
   endfunction

   // R3: default-constant instances, tick k ends at floor(k*INC/4096)
   task automatic full_step();
      bit e;
      if (!full_run) return;
      f_n++;
      if (f_k60 <= F_LINES) begin
         e = ((f_n + 1) == ((f_k60 * F_INC60) >> 12));
         chk(t60 == e, "R3 60Hz tick", longint'(t60), longint'(e));
         if (e) f_k60++;
      end
      if (f_k50 <= F_LINES) begin
         e = ((f_n + 1) == ((f_k50 * F_INC50) >> 12));
         chk(t50 == e, "R3 50Hz tick", longint'(t50), longint'(e));
         if (e) f_k50++;
      end
   endtask

   task automatic do_reset(input bit sel);
      rst = 1'b1;
      std_sel = sel;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         full_step();
         chk({line_tick, vblank_start, frame_wrap, audio_strobe} == 4'b0000,
             "R1 outputs in reset",
             longint'({line_tick, vblank_start, frame_wrap, audio_strobe}), 0);
      end
      rst = 1'b0;
      if (!full_run) begin
         rst_full = 1'b0;
         full_run = 1'b1;
         f_n = 0; f_k60 = 1; f_k50 = 1;
      end
      m_n = 0;
      m_act = sel;
      m_bound = inc_of(sel);
      m_line = 0;
      m_aud = 0;
      prev_tick = 1'b0;
      wait_first = 1'b1;
   endtask

   task automatic step();
      bit et, ev, ew, ea;
      @(negedge clk);
      full_step();
      m_n++;
      et = ((m_n + 1) == (m_bound >> 12));
      ev = et && (m_line + 1 == vbl_of(m_act));
      ew = et && (m_line == tot_of(m_act) - 1);
      ea = et && (m_aud == int'(T_AUD) - 1);
      chk(line_tick == et, "R2/R8 line_tick", longint'(line_tick), longint'(et));
      chk(vblank_start == ev, "R4 vblank_start", longint'(vblank_start), longint'(ev));
      chk(frame_wrap == ew, "R5/R7 frame_wrap", longint'(frame_wrap), longint'(ew));
      chk(audio_strobe == ea, "R6 audio_strobe", longint'(audio_strobe), longint'(ea));
      chk(!((vblank_start || frame_wrap || audio_strobe) && !line_tick) && !(line_tick && prev_tick),
          "R9 pulse shape", longint'({prev_tick, line_tick, vblank_start, frame_wrap, audio_strobe}),
          longint'({1'b0, line_tick, vblank_start && line_tick, frame_wrap && line_tick,
                    audio_strobe && line_tick}));
      if (wait_first && line_tick) begin
         chk(m_n + 1 == (inc_of(m_act) >> 12), "R1 first tick edge", m_n + 1, inc_of(m_act) >> 12);
         wait_first = 1'b0;
      end
      prev_tick = line_tick;
      if (($urandom % 16) == 0) std_sel = ~std_sel;
      if (et) begin
         m_aud  = (m_aud == int'(T_AUD) - 1) ? 0 : m_aud + 1;
         m_line = ew ? 0 : m_line + 1;
         if (ew) m_act = std_sel;
         m_bound += inc_of(m_act);
      end
   endtask

   initial begin
      void'($urandom(32'd24681));
      full_run = 1'b0;
      do_reset(1'b0);
      repeat (20000) step();
      do_reset(1'b1);
      repeat (26000) step();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 190000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule